// File: doc/BRIEF.md
# Phase/Frequency Detector with Configurable Outputs and Lock Indication

This block compares two synchronous edge streams, a divided reference (`ref_pulse_i`) and a divided oscillator feedback (`vco_pulse_i`). Both are sampled in one fast clock domain. A rising edge of the oscillator stream sets an internal "up" state. A rising edge of the reference sets a "down" state. Once both states are set and have overlapped for `MIN_PULSE` clocks, both are cleared together. Because of this forced overlap, a loop sitting in phase still produces a short coincident pulse on both outputs, so the detector has no dead zone.

The up/down state drives three outputs:
- An active-low pair, `phi_v_n_o` and `phi_r_n_o`. A polarity control can exchange the two, and the pair can be disabled.
- A three-state single-ended error output, given as a drive-enable plus a drive value. It can be inverted or forced to high impedance.
- A lock indicator. It stays high while the loop is quiet and drops for each correction pulse, widened by the overlap window. It is held low through reset and whenever it is disabled.

The control bits arrive as parallel inputs. A synchronous active-high reset clears all state.

Top module: `pfd_lock_top`

## Requirements
- R1: A rising edge (input high after being low on the previous clock) of `vco_pulse_i` sets the up state, and one of `ref_pulse_i` sets the down state. Each is visible on the outputs in the cycle after the sampling edge. An input held high for several clocks causes only one set.
- R2: Once up and down are both set, both stay set for exactly `MIN_PULSE` cycles and are then cleared together. A single state that is set alone stays set until the other one joins it.
- R3: With `cfg_swap_i`=0 and `cfg_dual_en_i`=1, `phi_v_n_o` is low exactly while up is set, and `phi_r_n_o` is low exactly while down is set.
- R4: With `cfg_swap_i`=1 and `cfg_dual_en_i`=1, `phi_r_n_o` follows up and `phi_v_n_o` follows down, both active low.
- R5: With `cfg_dual_en_i`=0, both `phi_r_n_o` and `phi_v_n_o` stay high.
- R6: With no inversion, the single-ended output drives 1 (`se_drive_en_o`=1, `se_drive_val_o`=1) while up is set alone. It drives 0 while down is set alone. It is high impedance (`se_drive_en_o`=0) when both or neither are set.
- R7: With `cfg_se_inv_i`=1, the driven value is inverted: up alone drives 0 and down alone drives 1. High impedance still applies when both or neither are set.
- R8: With `cfg_se_off_i`=1, `se_drive_en_o` stays 0 whatever the detector state.
- R9: With the lock output enabled, `lock_o` is low while up or down is set and for `MIN_PULSE` further cycles after both clear. Otherwise it is high.
- R10: `lock_o` is 0 while `cfg_lock_en_i` is 0 and during reset. An enable sampled on a clock edge takes effect in the cycle after that edge.
- R11: A clock edge with `rst` high clears the up state, the down state, the overlap counter and the input history. After such an edge the pair outputs are high, the single-ended output is high impedance and `lock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Divided reference stream |
| vco_pulse_i | input | 1 | Divided oscillator feedback stream |
| cfg_swap_i | input | 1 | Exchange roles of the active-low pair |
| cfg_dual_en_i | input | 1 | Enable the active-low pair |
| cfg_se_off_i | input | 1 | Force single-ended output to high impedance |
| cfg_se_inv_i | input | 1 | Invert single-ended driven value |
| cfg_lock_en_i | input | 1 | Enable lock indicator |
| phi_r_n_o | output | 1 | Active-low pair, reference side |
| phi_v_n_o | output | 1 | Active-low pair, oscillator side |
| se_drive_en_o | output | 1 | Single-ended output drive enable (0 = high impedance) |
| se_drive_val_o | output | 1 | Single-ended output value when driven |
| lock_o | output | 1 | Lock indicator, low pulses on correction |

## Verification
The bench sweeps every combination of the five control bits against arrival offsets from four cycles early to four cycles late, with input pulse widths of one to three clocks. It predicts each output cycle by cycle from the offset arithmetic.

Several corner cases are targeted:
- Coincident edges catch a design with a dead zone, which would show no overlap pulse, and an off-by-one overlap counter, which would give the wrong pulse length.
- Wide input pulses catch a detector that sets on the level instead of the edge; it would re-arm after the clear.
- The cycles after the clear catch a lock indicator that is not widened; it would rise too early.
- A reset issued with up pending, followed by a lone reference edge, shows whether reset really cleared the state. A stale up would turn the expected drive-low into high impedance.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef struct packed {
      logic swap;
      logic dual_en;
      logic se_off;
      logic se_inv;
      logic lock_en;
   } pfd_cfg_t;

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
   parameter int MIN_PULSE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_i,
   input  logic vco_i,
   output logic up_o,
   output logic dn_o
);

   logic ref_q, vco_q;
   logic up_q, dn_q;
   logic rise_ref, rise_vco;
   logic both;
   logic clr;

   assign rise_ref = ref_i & ~ref_q;
   assign rise_vco = vco_i & ~vco_q;
   assign both     = up_q & dn_q;

   generate
      if (MIN_PULSE < 1) begin : g_bad_min
         $error("pfd_edge_core: MIN_PULSE must be at least 1");
      end

      if (MIN_PULSE == 1) begin : g_direct
         assign clr = both;
      end else begin : g_count
         localparam int CW = $clog2(MIN_PULSE);
         localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (both) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
            end else begin
               cnt_q <= '0;
            end
         end

         assign clr = both && (cnt_q == LAST);

         // overlap must last longer than one cycle when the window is wider
         assert_min_overlap_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(both) |=> both);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q <= 1'b0;
         vco_q <= 1'b0;
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
      end else begin
         ref_q <= ref_i;
         vco_q <= vco_i;
         up_q  <= (up_q & ~clr) | rise_vco;
         dn_q  <= (dn_q & ~clr) | rise_ref;
      end
   end

   // a state set alone is never dropped before its partner arrives
   assert_single_persists_R2: assert property (@(posedge clk) disable iff (rst)
      (up_q && !dn_q) |=> up_q);

   assign up_o = up_q;
   assign dn_o = dn_q;

endmodule

// File: rtl/pfd_drive_map.sv
module pfd_drive_map
   import pfd_pkg::*;
(
   input  pfd_cfg_t cfg,
   input  logic     up_i,
   input  logic     dn_i,
   output logic     phi_r_n_o,
   output logic     phi_v_n_o,
   output logic     se_en_o,
   output logic     se_val_o
);

   logic up_act, dn_act;
   logic up_only, dn_only;

   assign up_act = cfg.dual_en & up_i;
   assign dn_act = cfg.dual_en & dn_i;

   always_comb begin
      if (cfg.swap) begin
         phi_r_n_o = ~up_act;
         phi_v_n_o = ~dn_act;
      end else begin
         phi_r_n_o = ~dn_act;
         phi_v_n_o = ~up_act;
      end
   end

   assign up_only  = up_i & ~dn_i;
   assign dn_only  = dn_i & ~up_i;
   assign se_en_o  = ~cfg.se_off & (up_only | dn_only);
   assign se_val_o = cfg.se_inv ? dn_only : up_only;

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
   parameter int MIN_PULSE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic up_i,
   input  logic dn_i,
   input  logic lock_en_i,
   output logic lock_o
);

   localparam int HW = $clog2(MIN_PULSE + 1);
   localparam logic [HW-1:0] LOAD = HW'(MIN_PULSE);

   logic          active;
   logic [HW-1:0] hold_q;
   logic          en_q;

   assign active = up_i | dn_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         en_q   <= 1'b0;
      end else begin
         en_q <= lock_en_i;
         if (active) begin
            hold_q <= LOAD;
         end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
         end
      end
   end

   assign lock_o = en_q & ~active & (hold_q == '0);

   // the low pulse outlasts the end of the correction
   assert_stretch_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> !lock_o);

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
   parameter int MIN_PULSE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_pulse_i,
   input  logic vco_pulse_i,
   input  logic cfg_swap_i,
   input  logic cfg_dual_en_i,
   input  logic cfg_se_off_i,
   input  logic cfg_se_inv_i,
   input  logic cfg_lock_en_i,
   output logic phi_r_n_o,
   output logic phi_v_n_o,
   output logic se_drive_en_o,
   output logic se_drive_val_o,
   output logic lock_o
);

   import pfd_pkg::*;

   pfd_cfg_t cfg;
   logic     up_w, dn_w;

   assign cfg.swap    = cfg_swap_i;
   assign cfg.dual_en = cfg_dual_en_i;
   assign cfg.se_off  = cfg_se_off_i;
   assign cfg.se_inv  = cfg_se_inv_i;
   assign cfg.lock_en = cfg_lock_en_i;

   pfd_edge_core #(.MIN_PULSE(MIN_PULSE)) i_core (
      .clk   (clk),
      .rst   (rst),
      .ref_i (ref_pulse_i),
      .vco_i (vco_pulse_i),
      .up_o  (up_w),
      .dn_o  (dn_w)
   );

   pfd_drive_map i_map (
      .cfg       (cfg),
      .up_i      (up_w),
      .dn_i      (dn_w),
      .phi_r_n_o (phi_r_n_o),
      .phi_v_n_o (phi_v_n_o),
      .se_en_o   (se_drive_en_o),
      .se_val_o  (se_drive_val_o)
   );

   pfd_lock_mon #(.MIN_PULSE(MIN_PULSE)) i_lock (
      .clk       (clk),
      .rst       (rst),
      .up_i      (up_w),
      .dn_i      (dn_w),
      .lock_en_i (cfg_lock_en_i),
      .lock_o    (lock_o)
   );

   // both pair outputs low together only during the forced overlap
   assert_dual_overlap_R3: assert property (@(posedge clk) disable iff (rst)
      (!phi_r_n_o && !phi_v_n_o) |-> (up_w && dn_w));

   // the single-ended output is driven only when exactly one state is set
   assert_se_single_R6: assert property (@(posedge clk) disable iff (rst)
      se_drive_en_o |-> (up_w ^ dn_w));

endmodule

// File: tb/test_pfd_lock_top.sv
`timescale 1ns/1ps
module test_pfd_lock_top;

   localparam int MP = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_p = 1'b0, vco_p = 1'b0;
   logic c_swap = 1'b0, c_dual = 1'b1, c_off = 1'b0, c_inv = 1'b0, c_lock = 1'b1;
   logic phi_r_n, phi_v_n, se_en, se_val, lock;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pfd_lock_top #(.MIN_PULSE(MP)) i_pfd_lock_top (
      .clk(clk), .rst(rst), .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
      .cfg_swap_i(c_swap), .cfg_dual_en_i(c_dual), .cfg_se_off_i(c_off),
      .cfg_se_inv_i(c_inv), .cfg_lock_en_i(c_lock),
      .phi_r_n_o(phi_r_n), .phi_v_n_o(phi_v_n), .se_drive_en_o(se_en),
      .se_drive_val_o(se_val), .lock_o(lock)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one scenario: vco edge at cycle tv, ref edge at cycle tr, pulses w wide
   task automatic run_case(input int cfgv, input int d, input int w);
      int tv, tr, m, lo, clrc;
      int upside_low, both_low;
      bit e_up, e_dn, e_phr, e_phv, e_en, e_val, e_lock;
      string tphi, tse, tlk;
      @(negedge clk);
      c_swap = cfgv[0]; c_dual = cfgv[1]; c_off = cfgv[2];
      c_inv = cfgv[3]; c_lock = cfgv[4];
      ref_p = 1'b0; vco_p = 1'b0;
      @(negedge clk);
      tv = 8; tr = 8 + d;
      m  = (tv > tr) ? tv : tr;
      lo = (tv < tr) ? tv : tr;
      clrc = m + MP;
      upside_low = 0; both_low = 0;
      tphi = c_dual ? (c_swap ? "R4" : "R3") : "R5";
      tse  = c_off ? "R8" : (c_inv ? "R7" : "R6");
      tlk  = c_lock ? "R9" : "R10";
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         e_up = (k >= tv) && (k < clrc);
         e_dn = (k >= tr) && (k < clrc);
         e_phv = !(c_dual && (c_swap ? e_dn : e_up));
         e_phr = !(c_dual && (c_swap ? e_up : e_dn));
         e_en  = !c_off && (e_up != e_dn);
         e_val = c_inv ? e_dn : e_up;
         e_lock = c_lock && !((k >= lo) && (k < m + 2 * MP));
         check(tphi, "phi_v_n", phi_v_n, e_phv);
         check(tphi, "phi_r_n", phi_r_n, e_phr);
         check(tse, "se_en", se_en, e_en);
         if (e_en) check(tse, "se_val", se_val, e_val);
         check(tlk, "lock", lock, e_lock);
         if (!(c_swap ? phi_r_n : phi_v_n)) upside_low++;
         if (!phi_r_n && !phi_v_n) both_low++;
         vco_p = (k + 1 >= tv) && (k + 1 < tv + w);
         ref_p = (k + 1 >= tr) && (k + 1 < tr + w);
      end
      if (c_dual) begin
         // R1: one set per edge even for wide pulses; R2: overlap exactly MP
         check("R1", "up-side low cycles", upside_low, clrc - tv);
         check("R2", "overlap cycles", both_low, MP);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state: R10 lock held low, R11 idle outputs
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", "lock in reset", lock, 0);
      check("R11", "phi_r_n in reset", phi_r_n, 1);
      check("R11", "phi_v_n in reset", phi_v_n, 1);
      check("R11", "se_en in reset", se_en, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R10", "lock one cycle after release", lock, 1);

      // reset with up pending
      vco_p = 1'b1;
      @(negedge clk);
      vco_p = 1'b0;
      check("R3", "phi_v_n up pending", phi_v_n, 0);
      rst = 1'b1;
      @(negedge clk);
      check("R11", "phi_v_n after reset", phi_v_n, 1);
      check("R11", "se_en after reset", se_en, 0);
      check("R11", "lock after reset", lock, 0);
      rst = 1'b0;
      ref_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0;
      check("R11", "se_en down alone", se_en, 1);
      check("R11", "se_val down alone", se_val, 0);
      vco_p = 1'b1;
      @(negedge clk);
      vco_p = 1'b0;
      repeat (10) @(negedge clk);
      check("R11", "phi_r_n settled", phi_r_n, 1);

      // sweep all control words, offsets and widths
      for (int c = 0; c < 32; c++)
         for (int d = -4; d <= 4; d++)
            run_case(c, d, 1 + ((d + 4 + c) % 3));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule